// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block is the execute-stage arithmetic unit of a small 16-bit processor. Each cycle in which `in_valid` is high it takes a 4-bit operation code, two data operands and the current four status flags. One clock later it presents a registered result, a destination write strobe and the next flag values. The operand `opa` is the destination register's value. The operand `opb` is either the source register or an immediate; the decoder upstream makes that choice.

Operation code 0000 does not name a single operation. It opens a unary group that acts on `opa`. The actual sub-operation is taken from the 4-bit `sub` input, which the decoder fills from the source-register field. This group holds the one-bit rotates and shifts, including rotate-through-carry and a left shift that inserts a 1. All subtractions produce a carry flag in the "no borrow" sense: a compare whose first operand is unsigned-below the second leaves C clear.

Top module: `alu16_core`

## Requirements
- R1: While reset is held, `out_valid`, `wr_en`, `result` and `flags_out` are zero. Each cycle with `in_valid` high gives `out_valid` high exactly one clock later, and results come out in issue order. A cycle without `in_valid` gives `out_valid` and `wr_en` low one clock later.
- R2: ADD (op 1000) yields opa+opb. ADC (op 1001) yields opa+opb+C, where C is the incoming carry. For both, C is the carry out, V is signed overflow, N is result bit 15, Z is set when the result is zero, and `wr_en` is high. Flag bits are packed as N bit 3, Z bit 2, V bit 1, C bit 0.
- R3: SUB (op 1010) yields opa-opb. SBC (op 1011) yields opa-opb-(1-C). For both, C is 1 exactly when no borrow occurs. V, N and Z follow as in R2, and `wr_en` is high.
- R4: SUBR (op 1100) and SBCR (op 1101) behave like SUB and SBC with the operands swapped, computing opb-opa.
- R5: CMP (op 0010) sets the flags exactly as SUB does. TST (op 0011) sets the flags exactly as AND does. Both keep `wr_en` low.
- R6: MOV (op 0001) yields opb. ANDN (op 0100) yields opa & ~opb. OR (op 0101), XOR (op 0110) and AND (op 0111) yield the matching bitwise result. These operations raise `wr_en`, set N and Z from the result, clear V and keep the incoming C.
- R7: WRSR (op 1110) loads `flags_out` from opb[3:0] and keeps `wr_en` low.
- R8: RDSR (op 1111) returns the incoming flags zero-extended to 16 bits. It raises `wr_en` and leaves the flags unchanged.
- R9: Unary group (op 0000) on opa, selected by `sub`:
  - ROR (1000) and ROL (1001) rotate opa by one bit.
  - SHR (1100) shifts right, filling with 0.
  - SHL (1101) shifts left, filling with 0.
  - SAR (1110) shifts right and keeps the sign bit.
  - C receives the bit moved out of the word, V is cleared, N and Z follow the result, and `wr_en` is high.
- R10: RCR (sub 1010) and RCL (sub 1011) rotate by one bit through the carry. The incoming C enters the vacated end, and the bit moved out becomes the new C.
- R11: Sub-code 1111 shifts opa left by one bit and inserts a 1 into bit 0. C receives the old bit 15.
- R12: Unary sub-codes 0000 to 0111 are unassigned. They keep `wr_en` low and pass the incoming flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation code |
| sub | input | 4 | Unary sub-operation, used when op is 0000 |
| opa | input | 16 | Destination register value |
| opb | input | 16 | Source register value or immediate |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Registered result is valid |
| result | output | 16 | Registered result |
| wr_en | output | 1 | Write the result to the destination register |
| flags_out | output | 4 | Next flags {N,Z,V,C} |

## Verification
The clocked properties sample `op`, `sub`, `opa`, `opb` and `flags_in` only in cycles where `in_valid` is high. They assume those inputs are known and steady around the clock edge. The properties look back at those inputs through a single-cycle `$past`, so they also rely on the result register capturing in every cycle. The bench satisfies this by changing inputs only on the falling edge and by holding reset across several edges before the first operation. It also mixes idle cycles with back-to-back issue, so that the one-cycle link between input and output is checked under both patterns.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_UNARY = 4'b0000,
        OP_MOV   = 4'b0001,
        OP_CMP   = 4'b0010,
        OP_TST   = 4'b0011,
        OP_ANDN  = 4'b0100,
        OP_OR    = 4'b0101,
        OP_XOR   = 4'b0110,
        OP_AND   = 4'b0111,
        OP_ADD   = 4'b1000,
        OP_ADC   = 4'b1001,
        OP_SUB   = 4'b1010,
        OP_SBC   = 4'b1011,
        OP_SUBR  = 4'b1100,
        OP_SBCR  = 4'b1101,
        OP_WRSR  = 4'b1110,
        OP_RDSR  = 4'b1111
    } alu_op_e;

    typedef enum logic [3:0] {
        UN_ROR = 4'b1000,
        UN_ROL = 4'b1001,
        UN_RCR = 4'b1010,
        UN_RCL = 4'b1011,
        UN_SHR = 4'b1100,
        UN_SHL = 4'b1101,
        UN_SAR = 4'b1110,
        UN_SXL = 4'b1111
    } un_op_e;

    localparam int FLAG_BITS = 4;

    // bit 3 N, bit 2 Z, bit 1 V, bit 0 C
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         ci;

    // Subtraction is x + ~y + carry; carry set means no borrow.
    always_comb begin
        x  = a;
        y  = ~b;
        ci = 1'b1;
        case (op)
            OP_ADD: begin
                y  = b;
                ci = 1'b0;
            end
            OP_ADC: begin
                y  = b;
                ci = cin;
            end
            OP_SBC: begin
                ci = cin;
            end
            OP_SUBR: begin
                x = b;
                y = ~a;
            end
            OP_SBCR: begin
                x  = b;
                y  = ~a;
                ci = cin;
            end
            default: begin
                // SUB and CMP use the defaults
            end
        endcase
    end

    assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    assign ovf         = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    always_comb begin
        case (op)
            OP_MOV:         res = b;
            OP_ANDN:        res = a & ~b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_AND, OP_TST: res = a & b;
            default:        res = a;
        endcase
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   sub,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         known
);

    always_comb begin
        known = sub[3];
        res   = a;
        cout  = cin;
        case (un_op_e'(sub))
            UN_ROR: begin
                res  = {a[0], a[W-1:1]};
                cout = a[0];
            end
            UN_ROL: begin
                res  = {a[W-2:0], a[W-1]};
                cout = a[W-1];
            end
            UN_RCR: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            UN_RCL: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            UN_SHR: begin
                res  = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            UN_SHL: begin
                res  = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            UN_SAR: begin
                res  = {a[W-1], a[W-1:1]};
                cout = a[0];
            end
            UN_SXL: begin
                res  = {a[W-2:0], 1'b1};
                cout = a[W-1];
            end
            default: begin
                res  = a;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           op,
    input  logic [3:0]           sub,
    input  logic [W-1:0]         opa,
    input  logic [W-1:0]         opb,
    input  logic [FLAG_BITS-1:0] flags_in,
    output logic                 out_valid,
    output logic [W-1:0]         result,
    output logic                 wr_en,
    output logic [FLAG_BITS-1:0] flags_out
);

    localparam int PAD = W - FLAG_BITS;

    typedef struct packed {
        logic         vld;
        logic         wen;
        logic [W-1:0] res;
        flags_t       fl;
    } state_t;

    state_t  st_d, st_q;
    alu_op_e op_e;
    flags_t  fin;

    logic [W-1:0] as_sum;
    logic         as_cout;
    logic         as_ovf;
    logic [W-1:0] lg_res;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    logic         sh_known;

    assign op_e = alu_op_e'(op);
    assign fin  = flags_t'(flags_in);

    alu16_addsub #(.W(W)) u_addsub (
        .op   (op_e),
        .a    (opa),
        .b    (opb),
        .cin  (fin.c),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    alu16_logic #(.W(W)) u_logic (
        .op  (op_e),
        .a   (opa),
        .b   (opb),
        .res (lg_res)
    );

    alu16_shift #(.W(W)) u_shift (
        .sub   (sub),
        .a     (opa),
        .cin   (fin.c),
        .res   (sh_res),
        .cout  (sh_cout),
        .known (sh_known)
    );

    function automatic flags_t make_flags(input logic [W-1:0] r, input logic v, input logic c);
        flags_t f;
        f.n = r[W-1];
        f.z = (r == '0);
        f.v = v;
        f.c = c;
        return f;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wen = 1'b0;
        if (in_valid) begin
            case (op_e)
                OP_UNARY: begin
                    if (sh_known) begin
                        st_d.res = sh_res;
                        st_d.wen = 1'b1;
                        st_d.fl  = make_flags(sh_res, 1'b0, sh_cout);
                    end else begin
                        st_d.res = opa;
                        st_d.fl  = fin;
                    end
                end
                OP_MOV, OP_ANDN, OP_OR, OP_XOR, OP_AND: begin
                    st_d.res = lg_res;
                    st_d.wen = 1'b1;
                    st_d.fl  = make_flags(lg_res, 1'b0, fin.c);
                end
                OP_TST: begin
                    st_d.res = lg_res;
                    st_d.fl  = make_flags(lg_res, 1'b0, fin.c);
                end
                OP_CMP: begin
                    st_d.res = as_sum;
                    st_d.fl  = make_flags(as_sum, as_ovf, as_cout);
                end
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_SUBR, OP_SBCR: begin
                    st_d.res = as_sum;
                    st_d.wen = 1'b1;
                    st_d.fl  = make_flags(as_sum, as_ovf, as_cout);
                end
                OP_WRSR: begin
                    st_d.res = opb;
                    st_d.fl  = flags_t'(opb[FLAG_BITS-1:0]);
                end
                OP_RDSR: begin
                    st_d.res = {{PAD{1'b0}}, flags_in};
                    st_d.wen = 1'b1;
                    st_d.fl  = fin;
                end
                default: begin
                    st_d.res = opa;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign wr_en     = st_q.wen;
    assign result    = st_q.res;
    assign flags_out = st_q.fl;

    // ---------------- assertions ----------------
    p_issue_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en));

    p_flag_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CMP || op == OP_TST)) |=> !wr_en);

    p_logic_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_MOV || op == OP_ANDN || op == OP_OR || op == OP_XOR || op == OP_AND))
        |=> (wr_en && !flags_out[1] && flags_out[0] == $past(flags_in[0])));

    p_flag_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_WRSR) |=> (!wr_en && flags_out == $past(opb[FLAG_BITS-1:0])));

    p_flag_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_RDSR) |=> (wr_en && flags_out == $past(flags_in)
                                         && result == {{PAD{1'b0}}, $past(flags_in)}));

    p_unary_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_UNARY && sub[3]) |=> (wr_en && !flags_out[1]));

    p_rotate_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_UNARY && sub == UN_RCL)
        |=> (result[0] == $past(flags_in[0]) && flags_out[0] == $past(opa[W-1])));

    p_insert_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_UNARY && sub == UN_SXL) |=> result[0]);

    p_unassigned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_UNARY && !sub[3]) |=> (!wr_en && flags_out == $past(flags_in)));

endmodule

// File: tb/sim_alu16_core.sv
`timescale 1ns/1ps
module sim_alu16_core;

    localparam time HALF = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [3:0]  sub = '0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic        wr_en;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] res;
        logic        wen;
        logic [3:0]  fl;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #HALF clk = ~clk;

    alu16_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .sub       (sub),
        .opa       (opa),
        .opb       (opb),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .wr_en     (wr_en),
        .flags_out (flags_out)
    );

    function automatic logic [3:0] nzvc(input logic [15:0] r, input logic v, input logic c);
        return {r[15], r == 16'h0, v, c};
    endfunction

    // Reference model written from the requirements
    function automatic exp_t model(input logic [3:0] o, input logic [3:0] s,
                                   input logic [15:0] a, input logic [15:0] b,
                                   input logic [3:0] f);
        exp_t e;
        int ua, ub, sa, sb2, u, sg, k;
        logic [15:0] r;
        logic c;
        c = f[0];
        k = c ? 1 : 0;
        ua = int'(a);
        ub = int'(b);
        sa = int'($signed(a));
        sb2 = int'($signed(b));
        e.res = 16'h0;
        e.wen = 1'b1;
        e.fl = f;
        e.req = "R1";
        case (o)
            4'b0000: begin
                case (s)
                    4'b1000: begin r = {a[0], a[15:1]};  e.fl = nzvc(r, 1'b0, a[0]);  e.req = "R9"; end
                    4'b1001: begin r = {a[14:0], a[15]}; e.fl = nzvc(r, 1'b0, a[15]); e.req = "R9"; end
                    4'b1010: begin r = {c, a[15:1]};     e.fl = nzvc(r, 1'b0, a[0]);  e.req = "R10"; end
                    4'b1011: begin r = {a[14:0], c};     e.fl = nzvc(r, 1'b0, a[15]); e.req = "R10"; end
                    4'b1100: begin r = a >> 1;           e.fl = nzvc(r, 1'b0, a[0]);  e.req = "R9"; end
                    4'b1101: begin r = a << 1;           e.fl = nzvc(r, 1'b0, a[15]); e.req = "R9"; end
                    4'b1110: begin r = 16'($signed(a) >>> 1); e.fl = nzvc(r, 1'b0, a[0]); e.req = "R9"; end
                    4'b1111: begin r = (a << 1) | 16'h1; e.fl = nzvc(r, 1'b0, a[15]); e.req = "R11"; end
                    default: begin r = a; e.wen = 1'b0; e.req = "R12"; end
                endcase
                e.res = r;
            end
            4'b0001, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111: begin
                case (o)
                    4'b0001: r = b;
                    4'b0100: r = a & ~b;
                    4'b0101: r = a | b;
                    4'b0110: r = a ^ b;
                    default: r = a & b;
                endcase
                e.res = r;
                e.fl = nzvc(r, 1'b0, c);
                e.wen = (o != 4'b0011);
                e.req = (o == 4'b0011) ? "R5" : "R6";
            end
            4'b1000, 4'b1001: begin
                u = ua + ub + ((o == 4'b1001) ? k : 0);
                sg = sa + sb2 + ((o == 4'b1001) ? k : 0);
                e.res = u[15:0];
                e.fl = nzvc(u[15:0], (sg > 32767 || sg < -32768), u > 65535);
                e.req = "R2";
            end
            4'b0010, 4'b1010, 4'b1011, 4'b1100, 4'b1101: begin
                if (o == 4'b1100 || o == 4'b1101) begin
                    u = ub - ua - ((o == 4'b1101) ? (1 - k) : 0);
                    sg = sb2 - sa - ((o == 4'b1101) ? (1 - k) : 0);
                    e.req = "R4";
                end else begin
                    u = ua - ub - ((o == 4'b1011) ? (1 - k) : 0);
                    sg = sa - sb2 - ((o == 4'b1011) ? (1 - k) : 0);
                    e.req = (o == 4'b0010) ? "R5" : "R3";
                end
                e.res = u[15:0];
                e.fl = nzvc(u[15:0], (sg > 32767 || sg < -32768), u >= 0);
                e.wen = (o != 4'b0010);
            end
            4'b1110: begin
                e.res = b;
                e.fl = b[3:0];
                e.wen = 1'b0;
                e.req = "R7";
            end
            default: begin
                e.res = {12'h0, f};
                e.fl = f;
                e.req = "R8";
            end
        endcase
        return e;
    endfunction

    task automatic send(input logic [3:0] o, input logic [3:0] s,
                        input logic [15:0] a, input logic [15:0] b, input logic [3:0] f);
        @(negedge clk);
        in_valid = 1'b1;
        op = o;
        sub = s;
        opa = a;
        opb = b;
        flags_in = f;
        sb.push_back(model(o, s, a, b, f));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op = $urandom_range(15, 0);
            opa = 16'hDEAD;
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R1: out_valid without issue (actual 1, expected 0)");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    checks++;
                    if (wr_en !== e.wen || flags_out !== e.fl || (e.wen && result !== e.res)) begin
                        errors++;
                        $display("FAIL %s: actual res=%h wen=%b fl=%b expected res=%h wen=%b fl=%b",
                                 e.req, result, wr_en, flags_out, e.res, e.wen, e.fl);
                    end
                end
            end else if (wr_en) begin
                checks++;
                errors++;
                $display("FAIL R1: wr_en without out_valid (actual 1, expected 0)");
            end
        end
    end

    initial begin
        #(HALF * 2 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || result !== 16'h0 || flags_out !== 4'h0) begin
            errors++;
            $display("FAIL R1: reset actual v=%b w=%b r=%h f=%b expected all zero",
                     out_valid, wr_en, result, flags_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2: add edges
        send(4'b1000, 4'h0, 16'h7FFF, 16'h0001, 4'h0);
        send(4'b1000, 4'h0, 16'hFFFF, 16'h0001, 4'h0);
        send(4'b1001, 4'h0, 16'h1234, 16'h0FFF, 4'h1);
        send(4'b1001, 4'h0, 16'hFFFF, 16'h0000, 4'h1);
        // R3: subtract and borrow
        send(4'b1010, 4'h0, 16'h0005, 16'h0003, 4'h0);
        send(4'b1010, 4'h0, 16'h0003, 16'h0005, 4'h0);
        send(4'b1010, 4'h0, 16'h8000, 16'h0001, 4'h0);
        send(4'b1011, 4'h0, 16'h0005, 16'h0005, 4'h0);
        send(4'b1011, 4'h0, 16'h0005, 16'h0005, 4'h1);
        idle(1);
        // R4: reversed subtract
        send(4'b1100, 4'h0, 16'h0003, 16'h0010, 4'h0);
        send(4'b1101, 4'h0, 16'h0010, 16'h0003, 4'h1);
        send(4'b1101, 4'h0, 16'h0003, 16'h0003, 4'h0);
        // R5: compare and test
        send(4'b0010, 4'h0, 16'h1111, 16'h1111, 4'h0);
        send(4'b0010, 4'h0, 16'h0001, 16'h0002, 4'hF);
        send(4'b0011, 4'h0, 16'hF0F0, 16'h0F0F, 4'h1);
        // R6: logic and move
        send(4'b0001, 4'h0, 16'hAAAA, 16'h0000, 4'h3);
        send(4'b0100, 4'h0, 16'hFF00, 16'hF0F0, 4'h1);
        send(4'b0101, 4'h0, 16'h8000, 16'h0001, 4'h2);
        send(4'b0110, 4'h0, 16'h5A5A, 16'h5A5A, 4'h0);
        send(4'b0111, 4'h0, 16'hFFFF, 16'h8001, 4'h1);
        // R7 and R8: status register access
        send(4'b1110, 4'h0, 16'h0000, 16'hFFF5, 4'h0);
        send(4'b1111, 4'h0, 16'h1234, 16'h4321, 4'hA);
        idle(2);
        // R9, R10, R11: unary group
        for (int s = 8; s < 16; s++) begin
            send(4'b0000, 4'(s), 16'h8001, 16'h0000, 4'h0);
            send(4'b0000, 4'(s), 16'h4002, 16'h0000, 4'h1);
        end
        send(4'b0000, 4'b1100, 16'h0001, 16'h0000, 4'h0);
        // R12: unassigned unary codes
        for (int s = 0; s < 8; s++) begin
            send(4'b0000, 4'(s), 16'hFFFF, 16'h0000, 4'(s + 5));
        end
        idle(3);

        // Mixed stream with gaps
        seed = 32'h1F2E3D4C;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] o, s, f;
            logic [15:0] a, b;
            seed = seed * 32'd1103515245 + 32'd12345;
            o = seed[19:16];
            s = seed[23:20];
            f = seed[27:24];
            seed = seed * 32'd1103515245 + 32'd12345;
            a = seed[31:16];
            seed = seed * 32'd1103515245 + 32'd12345;
            b = seed[31:16];
            send(o, s, a, b, f);
            if (seed[3:0] == 4'h0) idle(1);
        end
        idle(4);

        // R1: every issued item has come out
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: pending results actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule